// File: doc/BRIEF.md
# Endian-Aware Wide Operand Splitter

This block sits between a client that works in 64-bit operands and a bus port whose data path is only 8, 16 or 32 bits wide. The client raises a one-cycle start request carrying a direction, a base address, an endianness select and, for writes, the operand. The block then runs the transfer as a train of full-width beats on the narrow port. The beats go out at rising addresses, one port width apart. When the train ends, the block raises a one-cycle done pulse. For reads, the slices that come back are stitched into a 64-bit result.

The endianness select decides which slice of the operand belongs at the lowest address. The beats themselves always go out in rising address order. The narrow side uses a valid/acknowledge handshake and has a separate error response. An error on any beat ends the train at once and is reported together with done.

The control is a three-state machine:

- IDLE: waits for a start request.
- ISSUE: drives beats and waits for each response.
- REPORT: the one cycle in which done is high.

There are three transitions:

- Accept: IDLE to ISSUE, when a start request arrives in IDLE.
- Finish: ISSUE to REPORT, on an error response or on the acknowledge of the final beat.
- Release: REPORT to IDLE, unconditionally.

Top module: `wide_split_adapter`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it is released, `bus_valid`, `done` and `done_err` are low and `rdata` is zero.
- R2: A transfer that sees no error consists of exactly 64/PORT_W beats. Each beat drives the full PORT_W-bit data path, and `bus_write` equals the requested direction (1 = write).
- R3: The first beat's address is the base address with its three low bits forced to zero. Each later beat's address is PORT_W/8 higher than the one before.
- R4: With `req_big_end` = 1, beat i carries operand bits [(N-1-i)*PORT_W +: PORT_W], where N = 64/PORT_W. The lowest address therefore holds the most significant slice. For 0x0123456789ABCDEF over 32 bits, the beats carry 0x01234567 and then 0x89ABCDEF.
- R5: With `req_big_end` = 0, beat i carries operand bits [i*PORT_W +: PORT_W]. The lowest address therefore holds the least significant slice, and the same 32-bit example gives 0x89ABCDEF and then 0x01234567.
- R6: A beat's valid, address and data stay unchanged through any number of cycles without a response. The next beat is presented in the cycle after the acknowledge.
- R7: For reads, the data returned on beat i is placed in the operand slice that R4 or R5 assigns to beat i. The full 64-bit result is on `rdata` in the cycle where `done` is high.
- R8: `done` is high for exactly one cycle, the cycle after the last beat is acknowledged. `done_err` is low in that cycle, and `bus_valid` is low.
- R9: An error response (`bus_err` = 1, which takes priority over `bus_ack`) on any beat stops the train. No further beat is issued, and `done` and `done_err` are both high in the next cycle.
- R10: Start requests and changes to the request inputs while a transfer is in progress have no effect. The running transfer keeps its latched direction, endianness and operand, and no new transfer follows it.
- R11: `rdata` is cleared to zero when a request is accepted, so a write transfer finishes with `rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_start | input | 1 | Start request, sampled in IDLE |
| req_write | input | 1 | 1 = write operand, 0 = read operand |
| req_big_end | input | 1 | 1 = big-endian placement, 0 = little-endian |
| req_addr | input | ADDR_W | Base byte address, low three bits ignored |
| req_wdata | input | 64 | Operand to write |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | With done: the transfer ended on an error |
| rdata | output | 64 | Reassembled read operand |
| bus_valid | output | 1 | Narrow beat presented |
| bus_write | output | 1 | Direction of the current beat |
| bus_addr | output | ADDR_W | Byte address of the current beat |
| bus_wdata | output | PORT_W | Slice carried by the current write beat |
| bus_rdata | input | PORT_W | Slice returned by the target |
| bus_ack | input | 1 | Beat accepted |
| bus_err | input | 1 | Beat failed, abort |

## Verification
A stuck or skipped beat counter shows on the very next beat as a wrong `bus_addr` or a slice taken from the wrong operand position. It can also show as a `done` pulse that comes one beat early or late. A latched endianness flag that flips shows as swapped slices on the following beat, or as a read result with its halves exchanged in the `done` cycle. A state machine that fails to leave ISSUE or REPORT shows within one cycle: either `bus_valid` stays high after an error, or `done` stays high for a second cycle.

// File: rtl/split_pkg.sv
package split_pkg;
    localparam int OPERAND_W = 64;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_REPORT = 2'd2
    } split_state_e;
endpackage

// File: rtl/split_beat_ctr.sv
// Holds the aligned base address and the beat index; derives the beat address.
module split_beat_ctr #(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 32
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  load,
    input  logic                                  step,
    input  logic [ADDR_W-1:0]                     base_in,
    output logic [$clog2(64/PORT_W)-1:0]          idx,
    output logic [ADDR_W-1:0]                     addr
);
    localparam int NBEATS = 64 / PORT_W;
    localparam int IDX_W  = $clog2(NBEATS);
    localparam int STEP_B = PORT_W / 8;

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            idx    <= '0;
        end else if (load) begin
            base_q <= base_in & ~ADDR_W'(7);
            idx    <= '0;
        end else if (step) begin
            idx    <= idx + IDX_W'(1);
        end
    end

    assign addr = base_q + ADDR_W'(idx) * ADDR_W'(STEP_B);
endmodule

// File: rtl/split_order.sv
// Maps a beat index to an operand slot by endianness and selects that slice.
module split_order #(
    parameter int PORT_W = 32
) (
    input  logic [$clog2(64/PORT_W)-1:0] idx,
    input  logic                         big_end,
    input  logic [63:0]                  operand,
    output logic [$clog2(64/PORT_W)-1:0] slot,
    output logic [PORT_W-1:0]            slice
);
    localparam int NBEATS = 64 / PORT_W;
    localparam int IDX_W  = $clog2(NBEATS);

    logic [PORT_W-1:0] parts [NBEATS];

    for (genvar g = 0; g < NBEATS; g++) begin : g_part
        assign parts[g] = operand[g*PORT_W +: PORT_W];
    end

    assign slot  = big_end ? (IDX_W'(NBEATS - 1) - idx) : idx;
    assign slice = parts[slot];
endmodule

// File: rtl/split_gather.sv
// Collects returned read slices into their operand slots.
module split_gather #(
    parameter int PORT_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         capture,
    input  logic [$clog2(64/PORT_W)-1:0] slot,
    input  logic [PORT_W-1:0]            din,
    output logic [63:0]                  dout
);
    localparam int NBEATS = 64 / PORT_W;
    localparam int IDX_W  = $clog2(NBEATS);

    for (genvar g = 0; g < NBEATS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                dout[g*PORT_W +: PORT_W] <= '0;
            end else if (capture && (slot == IDX_W'(g))) begin
                dout[g*PORT_W +: PORT_W] <= din;
            end
        end
    end
endmodule

// File: rtl/wide_split_adapter.sv
module wide_split_adapter
    import split_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic              req_write,
    input  logic              req_big_end,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              done,
    output logic              done_err,
    output logic [63:0]       rdata,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [PORT_W-1:0] bus_wdata,
    input  logic [PORT_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);
    localparam int NBEATS = OPERAND_W / PORT_W;
    localparam int IDX_W  = $clog2(NBEATS);

    split_state_e state_q, state_d;

    logic             wr_q, big_q, err_q;
    logic [63:0]      op_q;
    logic [IDX_W-1:0] idx, slot;
    logic             accept, beat_ok, beat_err, last_beat;

    assign accept    = (state_q == ST_IDLE) && req_start;
    assign beat_err  = (state_q == ST_ISSUE) && bus_err;
    assign beat_ok   = (state_q == ST_ISSUE) && bus_ack && !bus_err;
    assign last_beat = (idx == IDX_W'(NBEATS - 1));

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: Accept, Finish, Release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_ISSUE;
            ST_ISSUE:  if (beat_err || (beat_ok && last_beat)) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Request latch and error flag
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= 1'b0;
            big_q <= 1'b0;
            op_q  <= '0;
            err_q <= 1'b0;
        end else if (accept) begin
            wr_q  <= req_write;
            big_q <= req_big_end;
            op_q  <= req_wdata;
            err_q <= 1'b0;
        end else if (beat_err) begin
            err_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        bus_valid = 1'b0;
        done      = 1'b0;
        done_err  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ISSUE:  bus_valid = 1'b1;
            ST_REPORT: begin
                done     = 1'b1;
                done_err = err_q;
            end
            default:   ;
        endcase
    end

    assign bus_write = wr_q;

    split_beat_ctr #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .step    (beat_ok),
        .base_in (req_addr),
        .idx     (idx),
        .addr    (bus_addr)
    );

    split_order #(.PORT_W(PORT_W)) u_order (
        .idx     (idx),
        .big_end (big_q),
        .operand (op_q),
        .slot    (slot),
        .slice   (bus_wdata)
    );

    split_gather #(.PORT_W(PORT_W)) u_gather (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .capture (beat_ok && !wr_q),
        .slot    (slot),
        .din     (bus_rdata),
        .dout    (rdata)
    );
endmodule

// File: rtl/split_chk.sv
module split_chk #(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_ack,
    input logic              bus_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              done,
    input logic              done_err
);
    localparam logic [2:0] LAST_OFF = 3'(8 - PORT_W / 8);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!bus_valid && !done && !done_err));

    // R6
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ack && !bus_err) |=> (bus_valid && $stable(bus_addr)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    final_ack_done_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ack && !bus_err && bus_addr[2:0] == LAST_OFF)
        |=> (done && !done_err && !bus_valid));

    // R9
    err_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_err) |=> (done && done_err && !bus_valid));

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && bus_valid));
endmodule

bind wide_split_adapter split_chk #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_split_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_addr  (bus_addr),
    .done      (done),
    .done_err  (done_err)
);

// File: tb/sim_wide_split_adapter.sv
module sim_wide_split_adapter;
    localparam int AW = 32;
    localparam int PW = 32;
    localparam int NB = 64 / PW;
    localparam int BY = PW / 8;

    typedef struct packed {
        logic        wr;
        logic        big;
        logic [31:0] addr;
        logic [63:0] op;
        logic [1:0]  waits;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{1'b1, 1'b1, 32'h0000_1000, 64'h0123_4567_89AB_CDEF, 2'd0},
        '{1'b1, 1'b0, 32'h0000_1000, 64'h0123_4567_89AB_CDEF, 2'd0},
        '{1'b0, 1'b1, 32'h0000_2008, 64'hDEAD_BEEF_CAFE_F00D, 2'd1},
        '{1'b0, 1'b0, 32'h0000_2010, 64'h1122_3344_5566_7788, 2'd2},
        '{1'b1, 1'b0, 32'h0000_3005, 64'hA5A5_0F0F_5A5A_F0F0, 2'd0},
        '{1'b1, 1'b1, 32'hFFFF_FFFB, 64'hFEDC_BA98_7654_3210, 2'd1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_start = 1'b0, req_write = 1'b0, req_big_end = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          done, done_err, bus_valid, bus_write;
    logic [63:0]   rdata;
    logic [AW-1:0] bus_addr;
    logic [PW-1:0] bus_wdata;
    logic [PW-1:0] bus_rdata = '0;
    logic          bus_ack = 1'b0, bus_err = 1'b0;

    int nchk = 0;
    int nbad = 0;

    always #5 clk = ~clk;

    wide_split_adapter #(.ADDR_W(AW), .PORT_W(PW)) u0 (
        .clk(clk), .rst(rst), .req_start(req_start), .req_write(req_write),
        .req_big_end(req_big_end), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .done_err(done_err), .rdata(rdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_err(bus_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Acts as the narrow-side target and checks every beat.
    task automatic run_op(input logic wr, input logic big, input logic [31:0] addr,
                          input logic [63:0] op, input int waits, input int err_beat,
                          input bit disturb);
        bit aborted = 0;
        @(negedge clk);
        req_start = 1'b1; req_write = wr; req_big_end = big;
        req_addr = addr; req_wdata = op;
        @(negedge clk);
        req_start = 1'b0;
        for (int i = 0; i < NB && !aborted; i++) begin
            logic [31:0] exp_addr;
            int slot;
            exp_addr = (addr & ~32'h7) + 32'(i * BY);
            slot = big ? (NB - 1 - i) : i;
            for (int w = 0; w < waits; w++) begin
                chk("R6 valid held", 64'(bus_valid), 64'd1);
                chk("R6 addr held", 64'(bus_addr), 64'(exp_addr));
                @(negedge clk);
            end
            chk("R2 beat valid", 64'(bus_valid), 64'd1);
            chk("R2 direction", 64'(bus_write), 64'(wr));
            chk("R3 address", 64'(bus_addr), 64'(exp_addr));
            if (wr) chk(big ? "R4 big slice" : "R5 little slice",
                        64'(bus_wdata), 64'(op[slot*PW +: PW]));
            bus_rdata = op[slot*PW +: PW];
            if (i == err_beat) begin
                bus_err = 1'b1;
                aborted = 1;
            end else begin
                bus_ack = 1'b1;
            end
            if (disturb && i == 0) begin
                // R10: new request and changed inputs mid-transfer
                req_start = 1'b1; req_big_end = ~big; req_write = ~wr;
                req_wdata = ~op; req_addr = addr + 32'h100;
            end
            @(negedge clk);
            bus_ack = 1'b0; bus_err = 1'b0; req_start = 1'b0;
        end
        chk(err_beat >= 0 ? "R9 done" : "R8 done", 64'(done), 64'd1);
        chk(err_beat >= 0 ? "R9 done_err" : "R8 done_err", 64'(done_err),
            64'(err_beat >= 0));
        chk(err_beat >= 0 ? "R9 no beat" : "R8 no beat", 64'(bus_valid), 64'd0);
        if (err_beat < 0) begin
            if (wr) chk("R11 rdata cleared", rdata, 64'd0);
            else    chk("R7 reassembly", rdata, op);
        end
        @(negedge clk);
        chk("R8 single pulse", 64'(done), 64'd0);
        chk(disturb ? "R10 no restart" : "R9 idle after", 64'(bus_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 64'(bus_valid), 64'd0);
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 rdata in reset", rdata, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 64'(bus_valid), 64'd0);
        chk("R1 done_err after reset", 64'(done_err), 64'd0);

        for (int v = 0; v < 6; v++)
            run_op(VECS[v].wr, VECS[v].big, VECS[v].addr, VECS[v].op,
                   int'(VECS[v].waits), -1, 1'b0);

        // R7 read then R11 clear on a following write
        run_op(1'b0, 1'b1, 32'h40, 64'h0F1E_2D3C_4B5A_6978, 0, -1, 1'b0);
        run_op(1'b1, 1'b1, 32'h48, 64'h1, 0, -1, 1'b0);

        // R10 disturbance while busy
        run_op(1'b1, 1'b1, 32'h800, 64'h0123_4567_89AB_CDEF, 1, -1, 1'b1);
        run_op(1'b0, 1'b0, 32'h810, 64'h7766_5544_3322_1100, 0, -1, 1'b1);

        // R9 error on first and on last beat
        run_op(1'b1, 1'b0, 32'h900, 64'hCAFE_0000_BABE_1111, 0, 0, 1'b0);
        run_op(1'b0, 1'b1, 32'h908, 64'h1234_5678_9ABC_DEF0, 1, NB - 1, 1'b0);

        // R9 error wins over simultaneous ack
        @(negedge clk);
        req_start = 1'b1; req_write = 1'b1; req_addr = 32'hA00;
        @(negedge clk);
        req_start = 1'b0;
        bus_ack = 1'b1; bus_err = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0; bus_err = 1'b0;
        chk("R9 err priority", 64'(done_err), 64'd1);
        chk("R9 err priority valid", 64'(bus_valid), 64'd0);
        @(negedge clk);

        // R1 reset in the middle of a transfer
        req_start = 1'b1; req_write = 1'b0; req_addr = 32'hB00;
        @(negedge clk);
        req_start = 1'b0;
        chk("R2 started", 64'(bus_valid), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-op reset valid", 64'(bus_valid), 64'd0);
        chk("R1 mid-op reset done", 64'(done), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 stays idle", 64'(bus_valid), 64'd0);

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule